// File: doc/BRIEF.md
# Weekly Alarm Match Comparator

This block stores a weekly alarm setting (a BCD minute, a BCD hour and a seven-bit day enable mask) and compares it with the running time of day once per minute. When the stored minute and hour equal the current time and the enable bit for the current weekday is set, it latches an alarm flag and pulls an active-low interrupt line. Both stay asserted until software clears them.

Software writes and reads the three settings through a small select/data port. The hour setting follows the encoding chosen by a 12/24-hour mode input. In 24-hour mode bit 5 is the tens-of-twenty digit. In 12-hour mode bit 5 is the afternoon marker, and the first hour after midnight or noon is written as 12 or 32. The stored hour is compared bit for bit with a current-hour value in the same encoding. A setting that no clock can ever reach is refused, so it never matches.

Top module: `wk_alarm_cmp`

## Requirements
- R1: After synchronous reset, alarm_flag is 0, alarm_n is 1 and all three settings read back as 0, so the mask is all zero and the alarm is disabled.
- R2: Select 0 is the minute setting (bits 6..4 tens, 3..0 units). A write stores bits 6..0 and bit 7 reads 0. rd_data shows the setting selected by rd_sel one cycle earlier.
- R3: Select 1 is the hour setting. Bits 5..0 are stored and bits 7..6 read 0.
- R4: Select 2 is the day mask. Bit d enables weekday count d (0..6), and bit 7 reads 0.
- R5: When min_tick is high, the minute and hour settings equal cur_min and cur_hour, and the mask bit selected by cur_dow is 1, alarm_flag is 1 and alarm_n is 0 on the next cycle.
- R6: Without min_tick, a clear flag stays clear whatever the time inputs are.
- R7: A mask bit of 0 for the current day, an all-zero mask or cur_dow = 7 gives no match.
- R8: With mode_24h = 1, the hour setting is 00..23 BCD, with bit 5 as the tens-of-twenty digit (for example 23 is 0x23).
- R9: With mode_24h = 0, bit 5 marks the afternoon, bit 4 is the tens digit and the hour is 01..12, with 12 (0x12) for the first morning hour and 0x32 for the first afternoon hour. 0x12 and 0x32 do not match each other.
- R10: A setting that is not a valid time never matches. Invalid settings are: minute units above 9 or tens above 5; in 24-hour mode, hours above 23 or units above 9; in 12-hour mode, hour 00 or hours above 12.
- R11: alarm_flag is sticky. It stays 1 through later non-matching ticks and is cleared one cycle after flag_clr. A match in the same cycle as flag_clr keeps it at 1.
- R12: alarm_n is always the inverse of alarm_flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the setting chosen by wr_sel |
| wr_sel | input | 2 | Write select: 0 minute, 1 hour, 2 day mask |
| wr_data | input | 8 | Write data |
| rd_sel | input | 2 | Read select, same encoding as wr_sel |
| rd_data | output | 8 | Registered read data, unused bits 0 |
| mode_24h | input | 1 | 1 = 24-hour encoding, 0 = 12-hour encoding |
| cur_min | input | 7 | Current BCD minute |
| cur_hour | input | 6 | Current BCD hour in the selected encoding |
| cur_dow | input | 3 | Current weekday count 0..6 |
| min_tick | input | 1 | One-cycle strobe at the minute boundary |
| flag_clr | input | 1 | Clears the alarm flag |
| alarm_flag | output | 1 | Sticky alarm flag |
| alarm_n | output | 1 | Active-low interrupt, inverse of alarm_flag |

## Verification
A read returns its data one cycle after rd_sel is presented, and a write is visible to a read presented on the following cycle. alarm_flag and alarm_n change one cycle after the min_tick or flag_clr cycle that causes the change. Each stimulus task queues its expected values stamped with the exact cycle in which they are due. The monitor compares them only in that cycle, sampling on the falling edge.

// File: rtl/wk_alarm_pkg.sv
package wk_alarm_pkg;
  typedef enum logic [1:0] {
    SEL_MIN  = 2'd0,
    SEL_HOUR = 2'd1,
    SEL_DAY  = 2'd2
  } sel_e;
endpackage

// File: rtl/wk_alarm_regs.sv
module wk_alarm_regs
  import wk_alarm_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int MIN_W  = 7,
  parameter int HR_W   = 6,
  parameter int DAYS   = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_sel,
  output logic [DATA_W-1:0] rd_data,
  output logic [MIN_W-1:0]  min_q,
  output logic [HR_W-1:0]   hr_q,
  output logic [DAYS-1:0]   day_q
);
  logic unused_bits;
  assign unused_bits = ^wr_data[DATA_W-1:DAYS];

  always_ff @(posedge clk) begin
    if (rst) begin
      min_q <= '0;
      hr_q  <= '0;
      day_q <= '0;
    end else if (wr_en) begin
      case (sel_e'(wr_sel))
        SEL_MIN:  min_q <= wr_data[MIN_W-1:0];
        SEL_HOUR: hr_q  <= wr_data[HR_W-1:0];
        SEL_DAY:  day_q <= wr_data[DAYS-1:0];
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      case (sel_e'(rd_sel))
        SEL_MIN:  rd_data <= DATA_W'(min_q);
        SEL_HOUR: rd_data <= DATA_W'(hr_q);
        SEL_DAY:  rd_data <= DATA_W'(day_q);
        default:  rd_data <= '0;
      endcase
    end
  end

  assert_min_write_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == SEL_MIN) |=> (min_q == $past(wr_data[MIN_W-1:0])));
  assert_min_pad_R2: assert property (@(posedge clk) disable iff (rst)
    ($past(rd_sel) == SEL_MIN) |-> (rd_data[DATA_W-1:MIN_W] == '0));
  assert_hour_pad_R3: assert property (@(posedge clk) disable iff (rst)
    ($past(rd_sel) == SEL_HOUR) |-> (rd_data[DATA_W-1:HR_W] == '0));
  assert_day_pad_R4: assert property (@(posedge clk) disable iff (rst)
    ($past(rd_sel) == SEL_DAY) |-> (rd_data[DATA_W-1:DAYS] == '0));
endmodule

// File: rtl/wk_alarm_valid.sv
module wk_alarm_valid #(
  parameter int MIN_W = 7,
  parameter int HR_W  = 6
) (
  input  logic [MIN_W-1:0] min_q,
  input  logic [HR_W-1:0]  hr_q,
  input  logic             mode_24h,
  output logic             set_ok
);
  logic [3:0] m_units, h_units;
  logic [2:0] m_tens;
  logic [1:0] h_tens;
  logic       min_ok, hr24_ok, hr12_ok;

  always_comb begin
    m_units = min_q[3:0];
    m_tens  = min_q[6:4];
    h_units = hr_q[3:0];
    h_tens  = hr_q[5:4];
    min_ok  = (m_units <= 4'd9) && (m_tens <= 3'd5);
    hr24_ok = (h_units <= 4'd9) &&
              ((h_tens < 2'd2) || ((h_tens == 2'd2) && (h_units <= 4'd3)));
    if (hr_q[4])
      hr12_ok = (h_units <= 4'd2);
    else
      hr12_ok = (h_units != 4'd0) && (h_units <= 4'd9);
    set_ok = min_ok && (mode_24h ? hr24_ok : hr12_ok);
  end
endmodule

// File: rtl/wk_alarm_match.sv
module wk_alarm_match #(
  parameter int MIN_W = 7,
  parameter int HR_W  = 6,
  parameter int DAYS  = 7,
  parameter int DOW_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [MIN_W-1:0] min_q,
  input  logic [HR_W-1:0]  hr_q,
  input  logic [DAYS-1:0]  day_q,
  input  logic             set_ok,
  input  logic [MIN_W-1:0] cur_min,
  input  logic [HR_W-1:0]  cur_hour,
  input  logic [DOW_W-1:0] cur_dow,
  input  logic             min_tick,
  input  logic             flag_clr,
  output logic             alarm_flag,
  output logic             alarm_n
);
  logic [DAYS-1:0] day_hit;
  logic            hit;

  for (genvar d = 0; d < DAYS; d++) begin : g_day
    assign day_hit[d] = day_q[d] && (cur_dow == DOW_W'(d));
  end

  assign hit = min_tick && set_ok && (|day_hit) &&
               (min_q == cur_min) && (hr_q == cur_hour);

  always_ff @(posedge clk) begin
    if (rst) begin
      alarm_flag <= 1'b0;
      alarm_n    <= 1'b1;
    end else if (hit) begin
      alarm_flag <= 1'b1;
      alarm_n    <= 1'b0;
    end else if (flag_clr) begin
      alarm_flag <= 1'b0;
      alarm_n    <= 1'b1;
    end
  end

  assert_no_tick_no_set_R6: assert property (@(posedge clk) disable iff (rst)
    (!alarm_flag && !min_tick) |=> !alarm_flag);
  assert_empty_mask_R7: assert property (@(posedge clk) disable iff (rst)
    (!alarm_flag && day_q == '0) |=> !alarm_flag);
  assert_invalid_set_R10: assert property (@(posedge clk) disable iff (rst)
    (!alarm_flag && !set_ok) |=> !alarm_flag);
  assert_sticky_R11: assert property (@(posedge clk) disable iff (rst)
    (alarm_flag && !flag_clr) |=> alarm_flag);
  assert_match_sets_R5: assert property (@(posedge clk) disable iff (rst)
    (min_tick && set_ok && min_q == cur_min && hr_q == cur_hour &&
     cur_dow < DOW_W'(DAYS) && day_q[cur_dow]) |=> alarm_flag);
  assert_irq_inverse_R12: assert property (@(posedge clk) disable iff (rst)
    alarm_n != alarm_flag);
endmodule

// File: rtl/wk_alarm_cmp.sv
module wk_alarm_cmp #(
  parameter int DATA_W = 8,
  parameter int MIN_W  = 7,
  parameter int HR_W   = 6,
  parameter int DAYS   = 7,
  parameter int DOW_W  = $clog2(DAYS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_sel,
  output logic [DATA_W-1:0] rd_data,
  input  logic              mode_24h,
  input  logic [MIN_W-1:0]  cur_min,
  input  logic [HR_W-1:0]   cur_hour,
  input  logic [DOW_W-1:0]  cur_dow,
  input  logic              min_tick,
  input  logic              flag_clr,
  output logic              alarm_flag,
  output logic              alarm_n
);
  logic [MIN_W-1:0] min_q;
  logic [HR_W-1:0]  hr_q;
  logic [DAYS-1:0]  day_q;
  logic             set_ok;

  wk_alarm_regs #(.DATA_W(DATA_W), .MIN_W(MIN_W), .HR_W(HR_W), .DAYS(DAYS)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .min_q(min_q), .hr_q(hr_q), .day_q(day_q)
  );

  wk_alarm_valid #(.MIN_W(MIN_W), .HR_W(HR_W)) u_valid (
    .min_q(min_q), .hr_q(hr_q), .mode_24h(mode_24h), .set_ok(set_ok)
  );

  wk_alarm_match #(.MIN_W(MIN_W), .HR_W(HR_W), .DAYS(DAYS), .DOW_W(DOW_W)) u_match (
    .clk(clk), .rst(rst), .min_q(min_q), .hr_q(hr_q), .day_q(day_q),
    .set_ok(set_ok), .cur_min(cur_min), .cur_hour(cur_hour), .cur_dow(cur_dow),
    .min_tick(min_tick), .flag_clr(flag_clr),
    .alarm_flag(alarm_flag), .alarm_n(alarm_n)
  );
endmodule

// File: tb/test_wk_alarm_cmp.sv
module test_wk_alarm_cmp;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] rd_sel = '0;
  logic [7:0] rd_data;
  logic       mode_24h = 1'b1;
  logic [6:0] cur_min = '0;
  logic [5:0] cur_hour = '0;
  logic [2:0] cur_dow = '0;
  logic       min_tick = 1'b0;
  logic       flag_clr = 1'b0;
  logic       alarm_flag, alarm_n;

  wk_alarm_cmp i_wk_alarm_cmp (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .mode_24h(mode_24h),
    .cur_min(cur_min), .cur_hour(cur_hour), .cur_dow(cur_dow),
    .min_tick(min_tick), .flag_clr(flag_clr),
    .alarm_flag(alarm_flag), .alarm_n(alarm_n)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  typedef struct {
    int         due;
    int         kind;   // 0 flag, 1 alarm_n, 2 rd_data
    logic [7:0] exp;
    string      req;
  } item_t;

  item_t q[$];
  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due == cyc) begin
      item_t it;
      logic [7:0] act;
      it = q.pop_front();
      case (it.kind)
        0:       act = {7'd0, alarm_flag};
        1:       act = {7'd0, alarm_n};
        default: act = rd_data;
      endcase
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s kind %0d actual %h expected %h at cycle %0d",
                 it.req, it.kind, act, it.exp, cyc);
      end
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic push(int kind, logic [7:0] exp, string req);
    item_t it;
    it.due = cyc + 1; it.kind = kind; it.exp = exp; it.req = req;
    q.push_back(it);
  endtask

  task automatic wr(logic [1:0] sel, logic [7:0] data);
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    step();
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(logic [1:0] sel, logic [7:0] exp, string req);
    rd_sel = sel;
    push(2, exp, req);
    step();
  endtask

  task automatic arm(logic [7:0] m, logic [7:0] h, logic [7:0] mask);
    wr(2'd0, m); wr(2'd1, h); wr(2'd2, mask);
  endtask

  task automatic tick(logic [6:0] m, logic [5:0] h, logic [2:0] d, logic clr,
                      logic exp, string req);
    cur_min = m; cur_hour = h; cur_dow = d; min_tick = 1'b1; flag_clr = clr;
    push(0, {7'd0, exp}, req);
    push(1, {7'd0, ~exp}, "R12");
    step();
    min_tick = 1'b0; flag_clr = 1'b0;
  endtask

  task automatic clear();
    flag_clr = 1'b1;
    push(0, 8'd0, "R11");
    push(1, 8'd1, "R12");
    step();
    flag_clr = 1'b0;
  endtask

  initial begin
    repeat (3) step();
    rst = 1'b0;
    // R1: reset state
    push(0, 8'd0, "R1"); push(1, 8'd1, "R1");
    rd_chk(2'd0, 8'h00, "R1");
    rd_chk(2'd1, 8'h00, "R1");
    rd_chk(2'd2, 8'h00, "R1");
    tick(7'h00, 6'h00, 3'd0, 1'b0, 1'b0, "R1_r7_empty_mask");
    // R2 R3 R4: readback with unused bits padded
    wr(2'd0, 8'hFF); rd_chk(2'd0, 8'h7F, "R2");
    wr(2'd1, 8'hFF); rd_chk(2'd1, 8'h3F, "R3");
    wr(2'd2, 8'hFF); rd_chk(2'd2, 8'h7F, "R4");
    wr(2'd0, 8'h45); rd_chk(2'd0, 8'h45, "R2");
    // R8: 24-hour match at 23:30 on day 6
    mode_24h = 1'b1;
    arm(8'h30, 8'h23, 8'h7F);
    tick(7'h31, 6'h23, 3'd6, 1'b0, 1'b0, "R5_minute_mismatch");
    tick(7'h30, 6'h23, 3'd6, 1'b0, 1'b1, "R8");
    // R11: sticky through a non-matching tick, then clear
    tick(7'h31, 6'h22, 3'd1, 1'b0, 1'b1, "R11");
    clear();
    // R6: matching time without tick
    cur_min = 7'h30; cur_hour = 6'h23; cur_dow = 3'd6;
    push(0, 8'd0, "R6");
    step();
    // R7: mask selection
    wr(2'd2, 8'h04);
    tick(7'h30, 6'h23, 3'd3, 1'b0, 1'b0, "R7");
    tick(7'h30, 6'h23, 3'd7, 1'b0, 1'b0, "R7");
    tick(7'h30, 6'h23, 3'd2, 1'b0, 1'b1, "R5");
    // R11: match wins over a clear in the same cycle
    tick(7'h30, 6'h23, 3'd2, 1'b1, 1'b1, "R11");
    clear();
    wr(2'd2, 8'h00);
    tick(7'h30, 6'h23, 3'd2, 1'b0, 1'b0, "R7");
    // R9: 12-hour encoding
    mode_24h = 1'b0;
    arm(8'h05, 8'h32, 8'h01);
    tick(7'h05, 6'h12, 3'd0, 1'b0, 1'b0, "R9");
    tick(7'h05, 6'h32, 3'd0, 1'b0, 1'b1, "R9");
    clear();
    wr(2'd1, 8'h12);
    tick(7'h05, 6'h12, 3'd0, 1'b0, 1'b1, "R9");
    clear();
    // R10: invalid settings
    mode_24h = 1'b1;
    wr(2'd1, 8'h32);
    tick(7'h05, 6'h32, 3'd0, 1'b0, 1'b0, "R10");
    wr(2'd1, 8'h24);
    tick(7'h05, 6'h24, 3'd0, 1'b0, 1'b0, "R10");
    wr(2'd1, 8'h10); wr(2'd0, 8'h5A);
    tick(7'h5A, 6'h10, 3'd0, 1'b0, 1'b0, "R10");
    wr(2'd0, 8'h60);
    tick(7'h60, 6'h10, 3'd0, 1'b0, 1'b0, "R10");
    mode_24h = 1'b0;
    wr(2'd0, 8'h00); wr(2'd1, 8'h00);
    tick(7'h00, 6'h00, 3'd0, 1'b0, 1'b0, "R10");
    wr(2'd1, 8'h13);
    tick(7'h00, 6'h13, 3'd0, 1'b0, 1'b0, "R10");
    wr(2'd1, 8'h11);
    tick(7'h00, 6'h11, 3'd0, 1'b0, 1'b1, "R9");
    repeat (3) step();
    if (q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard R5 actual %0d pending expected 0", q.size());
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R1 actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule